// File: doc/BRIEF.md
# Dual-Mode Greater-Than Comparator

This block is a combinational relational unit. It reports whether operand `a` is strictly larger than operand `b`. A single mode bit selects how both operands are read: as plain unsigned binary, or as two's-complement signed numbers. The result is a single flag.

Only one magnitude comparator exists in the block, and both interpretations use it. That comparator looks only at the bits below the top bit. The top bits of the two operands go to a small resolver. When the top bits match, the resolver passes the low-field result through. When they differ, it decides the answer directly, and the decision depends on the mode. The design therefore never builds a full-width signed comparator and a full-width unsigned comparator with a select between them.

The operand width is a parameter with a default of 8 bits, and it must be at least 2. The block has no clock, reset or internal state.

Top module: `dual_mode_gt`

## Requirements
- R1: With `mode` = 0, `a_gt_b` is 1 exactly when `a` is greater than `b` read as unsigned binary.
- R2: With `mode` = 1, `a_gt_b` is 1 exactly when `a` is greater than `b` read as two's-complement signed numbers.
- R3: With `mode` = 1 and differing top bits, the operand whose top bit is 0 is the larger one, so `a_gt_b` equals the top bit of `b`.
- R4: With `mode` = 0 and differing top bits, the operand whose top bit is 1 is the larger one, so `a_gt_b` equals the top bit of `a`.
- R5: When the top bits are equal, `a_gt_b` in either mode equals the unsigned greater-than of the lower W-1 bits, and both modes take this from one shared comparator.
- R6: When `a` equals `b`, `a_gt_b` is 0 in both modes.
- R7: In signed mode the all-ones, 1..100 and 1..001 patterns (-1, -4, -7 at width 8: 0xFF, 0xFC, 0xF9) order as -1 > -4 > -7 in every pairing.
- R8: The block is purely combinational: `a_gt_b` follows a change of `a`, `b` or `mode` with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | Left operand |
| b | input | W | Right operand |
| mode | input | 1 | 0 reads operands as unsigned, 1 as two's-complement signed |
| a_gt_b | output | 1 | High when `a` is strictly greater than `b` under the selected reading |

## Verification
The bench sweeps every operand pair at width 8 under both mode values. This covers the pairs whose top bits differ, which are resolved without the shared comparator and whose answer flips between modes. It also covers the pairs whose top bits are equal, which depend only on the low field, and the equal pairs, which must give 0. Directed vectors with negative values check the ordering of the -1, -4 and -7 patterns. A further vector changes the inputs between clock edges, to show that the flag follows the inputs with no register in the path.

// File: rtl/dmgt_pkg.sv
package dmgt_pkg;

    typedef enum logic {
        READ_UNSIGNED = 1'b0,
        READ_SIGNED   = 1'b1
    } read_mode_e;

    typedef struct packed {
        logic top_a;
        logic top_b;
        logic low_gt;
    } resolve_in_t;

endpackage

// File: rtl/dmgt_low_mag.sv
module dmgt_low_mag #(
    parameter int LW = 7
) (
    input  logic [LW-1:0] lo_a,
    input  logic [LW-1:0] lo_b,
    output logic          lo_gt
);

    logic gt_d;
    logic decided_d;

    // scan from the most significant low bit down; first differing bit decides
    always_comb begin
        gt_d      = 1'b0;
        decided_d = 1'b0;
        for (int i = LW - 1; i >= 0; i--) begin
            if (!decided_d && (lo_a[i] != lo_b[i])) begin
                gt_d      = lo_a[i];
                decided_d = 1'b1;
            end
        end
    end

    assign lo_gt = gt_d;

    // R5: a greater result on the low field implies the fields differ
    always_comb begin
        assert_low_gt_needs_diff_R5: assert (!lo_gt || (lo_a != lo_b))
            else $error("low field reports greater on equal fields");
    end

endmodule

// File: rtl/dmgt_top_resolve.sv
module dmgt_top_resolve
    import dmgt_pkg::*;
(
    input  resolve_in_t rin,
    input  read_mode_e  rmode,
    output logic        gt
);

    logic gt_d;

    always_comb begin
        if (rin.top_a == rin.top_b) begin
            gt_d = rin.low_gt;
        end else if (rmode == READ_SIGNED) begin
            gt_d = rin.top_b;   // sign bit 0 is the larger operand
        end else begin
            gt_d = rin.top_a;   // top bit 1 is the larger operand
        end
    end

    assign gt = gt_d;

    always_comb begin
        if (rin.top_a != rin.top_b && rmode == READ_SIGNED) begin
            assert_signed_top_differ_R3: assert (gt == !rin.top_a)
                else $error("signed top-bit resolution wrong");
        end
        if (rin.top_a != rin.top_b && rmode == READ_UNSIGNED) begin
            assert_unsigned_top_differ_R4: assert (gt == rin.top_a)
                else $error("unsigned top-bit resolution wrong");
        end
    end

endmodule

// File: rtl/dual_mode_gt.sv
module dual_mode_gt
    import dmgt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         mode,
    output logic         a_gt_b
);

    localparam int LW  = W - 1;
    localparam int TOP = W - 1;

    logic        low_gt;
    resolve_in_t rin_d;
    read_mode_e  rmode_d;

    // the single shared low-field comparator
    dmgt_low_mag #(.LW(LW)) u_low (
        .lo_a  (a[LW-1:0]),
        .lo_b  (b[LW-1:0]),
        .lo_gt (low_gt)
    );

    always_comb begin
        rin_d.top_a  = a[TOP];
        rin_d.top_b  = b[TOP];
        rin_d.low_gt = low_gt;
        rmode_d      = read_mode_e'(mode);
    end

    dmgt_top_resolve u_res (
        .rin   (rin_d),
        .rmode (rmode_d),
        .gt    (a_gt_b)
    );

    always_comb begin
        assert_equal_is_zero_R6: assert (!(a == b) || !a_gt_b)
            else $error("equal operands report greater");
        if (a[TOP] == b[TOP]) begin
            assert_same_top_uses_low_R5: assert (a_gt_b == low_gt)
                else $error("equal top bits not taken from low field");
        end
    end

endmodule

// File: tb/tb_dual_mode_gt.sv
module tb_dual_mode_gt;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;   // 125 MHz

    logic [7:0] a = '0;
    logic [7:0] b = '0;
    logic       mode = 1'b0;
    logic       a_gt_b;

    dual_mode_gt #(.W(8)) dut (
        .a      (a),
        .b      (b),
        .mode   (mode),
        .a_gt_b (a_gt_b)
    );

    typedef struct {
        logic [7:0] ea;
        logic [7:0] eb;
        logic       em;
        logic       exp;
        string      tag;
    } item_t;

    item_t q[$];
    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done = 0;

    function automatic logic ref_gt(logic [7:0] x, logic [7:0] y, logic m);
        if (m) return ($signed(x) > $signed(y));
        return (x > y);
    endfunction

    function automatic string tag_of(logic [7:0] x, logic [7:0] y, logic m);
        string base;
        base = m ? "R2" : "R1";
        if (x == y) return {base, "/R6"};
        if (x[7] != y[7]) return {base, m ? "/R3" : "/R4"};
        return {base, "/R5"};
    endfunction

    task automatic drive(input logic [7:0] x, input logic [7:0] y, input logic m, input string t);
        item_t it;
        @(posedge clk);
        a <= x; b <= y; mode <= m;
        it.ea = x; it.eb = y; it.em = m; it.exp = ref_gt(x, y, m); it.tag = t;
        q.push_back(it);
    endtask

    // monitor: compares away from the active edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            total++;
            if (a_gt_b !== it.exp) begin
                bad++;
                $display("FAIL %s a=%02h b=%02h mode=%0b actual=%0b expected=%0b",
                         it.tag, it.ea, it.eb, it.em, a_gt_b, it.exp);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset state: zero operands, equal -> 0 (R6)
        @(negedge clk);
        total++;
        if (a_gt_b !== 1'b0) begin
            bad++;
            $display("FAIL R6 reset actual=%0b expected=0", a_gt_b);
        end
        // R7: -1 > -4 > -7 in signed mode, all pairings
        drive(8'hFF, 8'hFC, 1'b1, "R7");
        drive(8'hFC, 8'hFF, 1'b1, "R7");
        drive(8'hFC, 8'hF9, 1'b1, "R7");
        drive(8'hF9, 8'hFC, 1'b1, "R7");
        drive(8'hFF, 8'hF9, 1'b1, "R7");
        drive(8'hF9, 8'hFF, 1'b1, "R7");
        // exhaustive sweep: R1..R6
        for (int m = 0; m < 2; m++)
            for (int x = 0; x < 256; x++)
                for (int y = 0; y < 256; y++)
                    drive(8'(x), 8'(y), 1'(m), tag_of(8'(x), 8'(y), 1'(m)));
        @(posedge clk);
        @(posedge clk);
        // R8: change inputs between edges, output follows without a clock edge
        @(negedge clk);
        #1;
        a = 8'h80; b = 8'h7F; mode = 1'b1;
        #1;
        total++;
        if (a_gt_b !== 1'b0) begin
            bad++;
            $display("FAIL R8 actual=%0b expected=0", a_gt_b);
        end
        mode = 1'b0;
        #1;
        total++;
        if (a_gt_b !== 1'b1) begin
            bad++;
            $display("FAIL R8 actual=%0b expected=1", a_gt_b);
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule